// File: doc/BRIEF.md
# Tiny Floating-Point Multiplier

This block takes two 8-bit floating-point operands and returns their registered product in the same 8-bit format. Each value has a sign in bit 7, a 4-bit biased exponent in bits 6:3 (bias 7) and a 3-bit fraction in bits 2:0. The fraction has an implied leading one, so a value is (-1)^s × 1.fff × 2^(e−7). There are no denormals. An exponent field of zero with a nonzero fraction is treated as an ordinary value with exponent 0.

Three arithmetic parts compute the normal result. The sign part XORs the operand signs. The significand part forms the 4×4-bit product of the two 1.fff values, normalises it, and raises a one-bit increment when the product is 2.0 or more. The exponent part adds the biased exponents, removes one bias and adds the increment.

A classifier then names each operand pair with one of five result classes:

| Class | Output |
|---|---|
| `K_NAN` | canonical NaN |
| `K_ZERO` | canonical zero |
| `K_SAT` | largest finite magnitude |
| `K_FLUSH` | zero |
| `K_NORM` | normal product |

The classes are checked in that order of precedence. A `unique case` on the class picks the output word, and that word is loaded into the result register on every rising clock edge. The result appears one cycle after the operands and holds until the next edge.

Top module: `fp8_mul_core`

## Requirements
- R1: While `rst_n` is low the result is 8'h00; otherwise the result presented after a rising edge depends only on the operands sampled at that edge (one cycle of latency).
- R2: If either operand has bits 6:0 equal to 7'h7F (exponent 1111, fraction 111, any sign), the result is 8'h7F.
- R3: If either operand has bits 6:0 equal to 7'h00 (any sign) and neither operand is NaN, the result is 8'h00.
- R4: A NaN operand overrides a zero operand: NaN paired with zero gives 8'h7F.
- R5: For a normal result, bit 7 is the XOR of the operand sign bits.
- R6: When the significand product 1.fA × 1.fB is 2.0 or more, the exponent gains one and the fraction is taken from the product bits just below its leading one.
- R7: Fraction bits beyond the kept three are truncated, never rounded (for example 1.125 × 1.125 yields 8'h3A).
- R8: If eA + eB − 7 + increment is 15 or more, the result is sign followed by 1111_110 (8'h7E or 8'hFE).
- R9: If eA + eB − 7 + increment is below 1, the result is 8'h00 regardless of sign.
- R10: An adjusted exponent of exactly 1 through 14 is passed through unchanged as the result exponent field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the result |
| op_a | input | 8 | First operand, sign/exponent/fraction |
| op_b | input | 8 | Second operand, sign/exponent/fraction |
| result | output | 8 | Registered product, same layout |

## Verification
All state in the block sits in one output register, so any fault shows on `result` in the cycle right after the operands that exposed it. There is nothing held across cycles to hide it. The bench checks every cycle against a behavioural model and sweeps all 65,536 operand pairs. A wrong class choice therefore shows as a wrong canonical code within one cycle, and a wrong normalisation or exponent shows as a wrong field within one cycle. Directed cases pin the class edges: exponent exactly 0, 1, 14 and 15, and NaN paired with zero.

// File: rtl/fp8_pkg.sv
package fp8_pkg;
    parameter int EXP_W = 4;
    parameter int FRC_W = 3;
    parameter int BIAS  = 7;
    localparam int WORD_W = 1 + EXP_W + FRC_W;
    localparam int SIG_W  = FRC_W + 1;
    localparam int PRD_W  = 2 * SIG_W;
    localparam int SUM_W  = EXP_W + 2;

    typedef enum logic [2:0] {
        K_NORM  = 3'd0,
        K_NAN   = 3'd1,
        K_ZERO  = 3'd2,
        K_SAT   = 3'd3,
        K_FLUSH = 3'd4
    } res_kind_e;
endpackage

// File: rtl/fp8_sign_unit.sv
module fp8_sign_unit (
    input  logic s_a,
    input  logic s_b,
    output logic s_out
);
    assign s_out = s_a ^ s_b;
endmodule

// File: rtl/fp8_sig_mul.sv
module fp8_sig_mul
    import fp8_pkg::*;
(
    input  logic [FRC_W-1:0] frc_a,
    input  logic [FRC_W-1:0] frc_b,
    output logic [FRC_W-1:0] frc_out,
    output logic             exp_inc
);
    logic [SIG_W-1:0] sig_a, sig_b;
    logic [PRD_W-1:0] prod;

    assign sig_a = {1'b1, frc_a};
    assign sig_b = {1'b1, frc_b};
    assign prod  = PRD_W'(sig_a) * PRD_W'(sig_b);

    // Product lies in [1.0, 4.0): the top bit marks the case that needs a right shift.
    assign exp_inc = prod[PRD_W-1];

    always_comb begin
        if (exp_inc) frc_out = prod[PRD_W-2 -: FRC_W];
        else         frc_out = prod[PRD_W-3 -: FRC_W];
    end
endmodule

// File: rtl/fp8_exp_unit.sv
module fp8_exp_unit
    import fp8_pkg::*;
(
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_b,
    input  logic             inc,
    output logic [EXP_W-1:0] exp_out,
    output logic             ovf,
    output logic             unf
);
    localparam logic signed [SUM_W-1:0] EMAX = SUM_W'((1 << EXP_W) - 1);
    localparam logic        [SUM_W-1:0] BIAS_V = SUM_W'(BIAS);

    logic        [SUM_W-1:0] sum_u;
    logic signed [SUM_W-1:0] sum_s;

    assign sum_u = SUM_W'(exp_a) + SUM_W'(exp_b) + SUM_W'(inc) - BIAS_V;
    assign sum_s = $signed(sum_u);

    assign ovf     = (sum_s >= EMAX);
    assign unf     = (sum_s < $signed(SUM_W'(1)));
    assign exp_out = sum_u[EXP_W-1:0];
endmodule

// File: rtl/fp8_mul_core.sv
module fp8_mul_core
    import fp8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] op_a,
    input  logic [7:0] op_b,
    output logic [7:0] result
);
    localparam logic [WORD_W-2:0] MAG_NAN  = '1;
    localparam logic [WORD_W-2:0] MAG_ZERO = '0;
    localparam logic [WORD_W-1:0] W_NAN    = {1'b0, MAG_NAN};
    localparam logic [WORD_W-2:0] MAG_MAXF = {{EXP_W{1'b1}}, {(FRC_W-1){1'b1}}, 1'b0};

    logic             s_a, s_b, s_res;
    logic [EXP_W-1:0] e_a, e_b, e_res;
    logic [FRC_W-1:0] f_a, f_b, f_res;
    logic             inc, ovf, unf;
    logic             nan_in, zero_in;
    res_kind_e        kind;
    logic [WORD_W-1:0] word_nxt, res_q;

    assign {s_a, e_a, f_a} = op_a;
    assign {s_b, e_b, f_b} = op_b;

    fp8_sign_unit u_sign (
        .s_a   (s_a),
        .s_b   (s_b),
        .s_out (s_res)
    );

    fp8_sig_mul u_sig (
        .frc_a   (f_a),
        .frc_b   (f_b),
        .frc_out (f_res),
        .exp_inc (inc)
    );

    fp8_exp_unit u_exp (
        .exp_a   (e_a),
        .exp_b   (e_b),
        .inc     (inc),
        .exp_out (e_res),
        .ovf     (ovf),
        .unf     (unf)
    );

    assign nan_in  = (op_a[WORD_W-2:0] == MAG_NAN)  || (op_b[WORD_W-2:0] == MAG_NAN);
    assign zero_in = (op_a[WORD_W-2:0] == MAG_ZERO) || (op_b[WORD_W-2:0] == MAG_ZERO);

    // Class precedence: NaN, zero, overflow, underflow, normal.
    always_comb begin
        if (nan_in)       kind = K_NAN;
        else if (zero_in) kind = K_ZERO;
        else if (ovf)     kind = K_SAT;
        else if (unf)     kind = K_FLUSH;
        else              kind = K_NORM;
    end

    always_comb begin
        unique case (kind)
            K_NAN:   word_nxt = W_NAN;
            K_ZERO:  word_nxt = '0;
            K_SAT:   word_nxt = {s_res, MAG_MAXF};
            K_FLUSH: word_nxt = '0;
            K_NORM:  word_nxt = {s_res, e_res, f_res};
            default: word_nxt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= word_nxt;
    end

    assign result = res_q;

    a_r2_nan_code: assert property (@(posedge clk) disable iff (!rst_n)
        nan_in |=> (result == W_NAN));

    a_r3_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_in && !nan_in) |=> (result == '0));

    a_r5_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_NORM) |=> (result[WORD_W-1] == $past(op_a[WORD_W-1] ^ op_b[WORD_W-1])));

    a_r8_top_exp_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (result[WORD_W-2 -: EXP_W] == '1) |-> (result == W_NAN || result[WORD_W-2:0] == MAG_MAXF));

    a_r9_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_FLUSH) |=> (result == '0));

    a_r10_norm_exp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_NORM) |=> (result[WORD_W-2 -: EXP_W] != '0 && result[WORD_W-2 -: EXP_W] != '1));
endmodule

// File: tb/tb_fp8_mul_core.sv
`timescale 1ns/1ps
module tb_fp8_mul_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = 8'h00;
    logic [7:0] op_b = 8'h00;
    logic [7:0] result;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    fp8_mul_core dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_a   (op_a),
        .op_b   (op_b),
        .result (result)
    );

    function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] b);
        int ea, eb, sa, sb, p, e, m;
        logic sg;
        if ((a & 8'h7F) == 8'h7F || (b & 8'h7F) == 8'h7F) return 8'h7F;
        if ((a & 8'h7F) == 8'h00 || (b & 8'h7F) == 8'h00) return 8'h00;
        sg = a[7] ^ b[7];
        ea = (a >> 3) & 15;
        eb = (b >> 3) & 15;
        sa = 8 + (a & 7);
        sb = 8 + (b & 7);
        p = sa * sb;
        if (p >= 128) begin
            e = ea + eb - 7 + 1;
            m = (p / 16) % 8;
        end else begin
            e = ea + eb - 7;
            m = (p / 8) % 8;
        end
        if (e >= 15) return {sg, 7'h7E};
        if (e < 1) return 8'h00;
        return {sg, 4'(e), 3'(m)};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: result=%h expected=%h", tag, act, expv);
        end
    endtask

    // Apply one operand pair, then compare one cycle later.
    task automatic step(input string tag, input logic [7:0] a, input logic [7:0] b);
        logic [7:0] e;
        @(negedge clk);
        op_a = a;
        op_b = b;
        exp_q.push_back(model(a, b));
        @(posedge clk);
        #1;
        e = exp_q.pop_front();
        check(tag, result, e);
    endtask

    task automatic step_lit(input string tag, input logic [7:0] a, input logic [7:0] b,
                            input logic [7:0] lit);
        @(negedge clk);
        op_a = a;
        op_b = b;
        @(posedge clk);
        #1;
        check(tag, result, lit);
    endtask

    initial begin
        #(5.0 * 190000);
        n_fail++;
        $display("FAIL watchdog: result=%h expected=done", result);
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        op_a = 8'h3C;
        op_b = 8'h3C;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", result, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        step_lit("R10 example", 8'h2A, 8'h19, 8'h0B);
        step_lit("R10 one", 8'h38, 8'h38, 8'h38);
        step_lit("R6 normalise", 8'h3C, 8'h3C, 8'h41);
        step_lit("R5 sign neg", 8'hBC, 8'h3C, 8'hC1);
        step_lit("R5 sign both", 8'hBC, 8'hBC, 8'h41);
        step_lit("R7 truncate", 8'h39, 8'h39, 8'h3A);
        step_lit("R8 saturate", 8'h70, 8'h70, 8'h7E);
        step_lit("R8 saturate neg", 8'hF0, 8'h70, 8'hFE);
        step_lit("R8 exp exactly 15", 8'h78, 8'h38, 8'h7E);
        step_lit("R10 exp 14", 8'h70, 8'h38, 8'h70);
        step_lit("R10 exp 1", 8'h08, 8'h38, 8'h08);
        step_lit("R9 exp 0", 8'h08, 8'h30, 8'h00);
        step_lit("R9 flush neg", 8'h88, 8'h08, 8'h00);
        step_lit("R2 nan a", 8'h7F, 8'h38, 8'h7F);
        step_lit("R2 nan b neg", 8'h45, 8'hFF, 8'h7F);
        step_lit("R4 nan over zero", 8'hFF, 8'h00, 8'h7F);
        step_lit("R4 zero then nan", 8'h80, 8'h7F, 8'h7F);
        step_lit("R3 zero neg", 8'h80, 8'h45, 8'h00);
        step_lit("R3 zero b", 8'hC5, 8'h00, 8'h00);

        for (int i = 0; i < 65536; i++) begin
            step("R1 R6 R7 sweep", 8'(i >> 8), 8'(i & 255));
        end

        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", result, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1 after reset", 8'h3C, 8'hBC);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule